// File: doc/BRIEF.md
# DTMF Digit Command Receiver

This block takes the digit command that drives a dual-tone generator and turns it into a registered digit index and a tone-enable flag in the system clock domain. It accepts commands in one of two forms chosen by a mode pin. In serial form a host shifts a 5-bit word on a data pin, clocked by its own slow serial clock. In parallel form the host sets four data pins and then pulls the active-low chip enable down.

All pins are asynchronous to the system clock. They pass through a shared two-flop synchronizer before any edge is detected. Serial words are assembled least significant bit first, and a bit is taken on each falling edge of the serial clock. A bit counter closes the word after the fifth bit. The assembled word is then classified into one of three kinds: a dual-tone digit, the all-ones stop word, or an unused word that is rejected. In parallel mode, the falling edge of chip enable captures the 4-bit pin code. Taking chip enable high, or changing mode, silences the tone.

Top module: `dtmf_cmd_if`

## Requirements
- R1: After reset, `digit_o` is 0, `tone_en_o` is 0, `code_valid_o` is 0, and no serial bits are held.
- R2: In serial mode with chip enable low, each falling edge of `sclk_i` takes one bit of `sdata_i`. The first bit becomes bit 0 and the fifth becomes bit 4 (the MSB). A word with bit 4 equal to 0 (values 0x00 to 0x0F) is a digit: `digit_o` becomes bits 3:0 and `tone_en_o` becomes 1.
- R3: Every accepted digit command, serial or parallel, raises `code_valid_o` for exactly one system clock. Stop words and unused words raise no pulse.
- R4: The serial word 0x1F (all ones) is a stop command. It clears `tone_en_o`, leaves `digit_o` unchanged, and gives no `code_valid_o` pulse.
- R5: The serial words 0x10 to 0x1E are unused. They leave `digit_o` and `tone_en_o` unchanged and give no `code_valid_o` pulse.
- R6: While `ce_n_i` is high, partially received serial bits are discarded and `tone_en_o` is 0. The next complete 5-bit word after chip enable returns low is decoded correctly.
- R7: In parallel mode (`mode_par_i` = 1), a falling edge of `ce_n_i` captures `pdata_i` into `digit_o` and sets `tone_en_o` to 1.
- R8: In parallel mode, `pdata_i` changes while `ce_n_i` stays low do not alter `digit_o`. Raising `ce_n_i` clears `tone_en_o`.
- R9: Serial clock activity has no effect in parallel mode, and `pdata_i` has no effect in serial mode.
- R10: A change of `mode_par_i` clears `tone_en_o` and discards any partial serial word.
- R11: Output latency is four system clock rising edges. `code_valid_o` is high after the fourth rising edge following the application of the final serial falling edge, and is low after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par_i | input | 1 | 1 = parallel mode, 0 = serial mode (asynchronous) |
| ce_n_i | input | 1 | Active-low chip enable (asynchronous) |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge (asynchronous) |
| sdata_i | input | 1 | Serial data, LSB first (asynchronous) |
| pdata_i | input | 4 | Parallel digit code (asynchronous) |
| digit_o | output | 4 | Registered digit index for the tone synthesizer |
| tone_en_o | output | 1 | Registered tone enable |
| code_valid_o | output | 1 | One-cycle strobe for each accepted digit command |

## Verification
A serial bit counter that slips by one position shows up as a rotated `digit_o` on the very next command, and as a wrong classification for words whose bit 4 is involved. A counter that is not cleared when chip enable rises corrupts the first word after the abort. A stale edge-detect register shows up as a missing or doubled `code_valid_o` pulse within four system clocks of the offending pin edge. The bench compares every command against a model of the digit, tone and pulse count, and checks the exact cycle of the strobe.

// File: rtl/dtmf_cmd_pkg.sv
package dtmf_cmd_pkg;
  localparam int SER_BITS = 5;
  localparam int PAR_BITS = 4;
  localparam int DIGIT_W  = 4;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    K_DIGIT  = 2'd0,
    K_STOP   = 2'd1,
    K_UNUSED = 2'd2
  } kind_e;
endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dtmf_ser_rx.sv
module dtmf_ser_rx #(
  parameter int CODE_W = dtmf_cmd_pkg::SER_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              stb_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic              sclk_q;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] sh;

  assign fall = en_i & sclk_q & ~sclk_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
      stb_o  <= 1'b0;
      code_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      stb_o  <= 1'b0;
      if (!en_i) begin
        cnt <= '0;
      end else if (fall) begin
        if (cnt == LAST) begin
          cnt    <= '0;
          stb_o  <= 1'b1;
          code_o <= {sdata_i, sh[CODE_W-1:1]};
        end else begin
          cnt <= cnt + 1'b1;
          sh  <= {sdata_i, sh[CODE_W-1:1]};
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= LAST); // R2
  AST_ABORT_CLR: assert property (@(posedge clk) disable iff (rst) !en_i |=> cnt == '0); // R6
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) stb_o |=> !stb_o); // R3
endmodule

// File: rtl/dtmf_par_cap.sv
module dtmf_par_cap #(
  parameter int W = dtmf_cmd_pkg::PAR_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         ce_n_i,
  input  logic [W-1:0] data_i,
  output logic         stb_o,
  output logic [W-1:0] code_o
);
  logic ce_q;
  logic fire;

  assign fire = en_i & ce_q & ~ce_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      stb_o  <= 1'b0;
      code_o <= '0;
    end else begin
      ce_q  <= ce_n_i;
      stb_o <= fire;
      if (fire) code_o <= data_i;
    end
  end

  AST_PAR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst) stb_o |=> !stb_o); // R7
endmodule

// File: rtl/dtmf_cmd_dec.sv
module dtmf_cmd_dec
  import dtmf_cmd_pkg::*;
#(
  parameter int SER_W = SER_BITS,
  parameter int PAR_W = PAR_BITS,
  parameter int DIG_W = DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             ser_stb_i,
  input  logic [SER_W-1:0] ser_code_i,
  input  logic             par_stb_i,
  input  logic [PAR_W-1:0] par_code_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             tone_o,
  output logic             valid_o
);
  kind_e kind;

  always_comb begin
    if (&ser_code_i)                  kind = K_STOP;
    else if (!ser_code_i[SER_W-1])    kind = K_DIGIT;
    else                              kind = K_UNUSED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_o <= '0;
      tone_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        tone_o <= 1'b0;
      end else if (par_stb_i) begin
        digit_o <= DIG_W'(par_code_i);
        tone_o  <= 1'b1;
        valid_o <= 1'b1;
      end else if (ser_stb_i) begin
        case (kind)
          K_DIGIT: begin
            digit_o <= DIG_W'(ser_code_i);
            tone_o  <= 1'b1;
            valid_o <= 1'b1;
          end
          K_STOP:  tone_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o); // R3
  AST_VALID_TONE: assert property (@(posedge clk) disable iff (rst) valid_o |-> tone_o); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) (ser_stb_i && !par_stb_i && &ser_code_i) |=> (!tone_o && $stable(digit_o) && !valid_o)); // R4
  AST_UNUSED_HOLDS: assert property (@(posedge clk) disable iff (rst) (ser_stb_i && !par_stb_i && !clear_i && ser_code_i[SER_W-1] && !(&ser_code_i)) |=> ($stable(digit_o) && $stable(tone_o) && !valid_o)); // R5
endmodule

// File: rtl/dtmf_cmd_if.sv
module dtmf_cmd_if
  import dtmf_cmd_pkg::*;
#(
  parameter int PAR_W  = PAR_BITS,
  parameter int SER_W  = SER_BITS,
  parameter int DIG_W  = DIGIT_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_par_i,
  input  logic             ce_n_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic [PAR_W-1:0] pdata_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             tone_en_o,
  output logic             code_valid_o
);
  localparam int SYNC_W = 4 + PAR_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b0, {PAR_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              mode_s, ce_n_s, sclk_s, sdata_s;
  logic [PAR_W-1:0]  pdata_s;
  logic              mode_q, mode_chg, clear;
  logic              ser_en, par_en;
  logic              ser_stb, par_stb;
  logic [SER_W-1:0]  ser_code;
  logic [PAR_W-1:0]  par_code;

  dtmf_sync #(.WIDTH(SYNC_W), .STAGES(STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({mode_par_i, ce_n_i, sclk_i, sdata_i, pdata_i}),
    .q_o (sync_q)
  );

  assign {mode_s, ce_n_s, sclk_s, sdata_s, pdata_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_s;
  end

  assign mode_chg = mode_q ^ mode_s;
  assign clear    = ce_n_s | mode_chg;
  assign ser_en   = ~mode_s & ~ce_n_s & ~mode_chg;
  assign par_en   = mode_s & ~mode_chg;

  dtmf_ser_rx #(.CODE_W(SER_W)) ser_i (
    .clk     (clk),
    .rst     (rst),
    .en_i    (ser_en),
    .sclk_i  (sclk_s),
    .sdata_i (sdata_s),
    .stb_o   (ser_stb),
    .code_o  (ser_code)
  );

  dtmf_par_cap #(.W(PAR_W)) par_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (par_en),
    .ce_n_i (ce_n_s),
    .data_i (pdata_s),
    .stb_o  (par_stb),
    .code_o (par_code)
  );

  dtmf_cmd_dec #(.SER_W(SER_W), .PAR_W(PAR_W), .DIG_W(DIG_W)) dec_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (clear),
    .ser_stb_i  (ser_stb),
    .ser_code_i (ser_code),
    .par_stb_i  (par_stb),
    .par_code_i (par_code),
    .digit_o    (digit_o),
    .tone_o     (tone_en_o),
    .valid_o    (code_valid_o)
  );

  AST_CE_CLEARS: assert property (@(posedge clk) disable iff (rst) ce_n_s |=> !tone_en_o); // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst) !(ser_stb && par_stb)); // R9
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst) mode_chg |=> !tone_en_o); // R10
endmodule

// File: tb/dtmf_cmd_if_tb_top.sv
`timescale 1ns/1ps
module dtmf_cmd_if_tb_top;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_par = 1'b0;
  logic       ce_n = 1'b1;
  logic       sclk = 1'b1;
  logic       sdata = 1'b0;
  logic [3:0] pdata = '0;
  logic [3:0] digit;
  logic       tone_en;
  logic       code_valid;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  int exp_pulses = 0;
  logic [3:0] exp_digit = '0;
  logic       exp_tone = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtmf_cmd_if dut_i (
    .clk          (clk),
    .rst          (rst),
    .mode_par_i   (mode_par),
    .ce_n_i       (ce_n),
    .sclk_i       (sclk),
    .sdata_i      (sdata),
    .pdata_i      (pdata),
    .digit_o      (digit),
    .tone_en_o    (tone_en),
    .code_valid_o (code_valid)
  );

  always @(negedge clk) if (!rst && code_valid) pulses++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    sdata = b;
    tick(HALF);
    sclk = 1'b0;
    tick(HALF);
    sclk = 1'b1;
  endtask

  task automatic ser_send(input logic [4:0] c);
    for (int i = 0; i < 5; i++) ser_bit(c[i]);
    tick(8);
  endtask

  function automatic string kind_req(input logic [4:0] c);
    if (c == 5'h1F) return "R4";
    if (c[4]) return "R5";
    return "R2";
  endfunction

  task automatic model_ser(input logic [4:0] c);
    if (c == 5'h1F) exp_tone = 1'b0;
    else if (!c[4]) begin
      exp_digit = c[3:0];
      exp_tone = 1'b1;
      exp_pulses++;
    end
  endtask

  task automatic ser_cmd_check(input logic [4:0] c);
    ser_send(c);
    model_ser(c);
    check({kind_req(c), " digit"}, digit, exp_digit);
    check({kind_req(c), " tone"}, tone_en, exp_tone);
    check("R3 pulses", pulses, exp_pulses);
  endtask

  task automatic par_cmd_check(input logic [3:0] c);
    pdata = c;
    tick(4);
    ce_n = 1'b0;
    tick(8);
    exp_digit = c;
    exp_tone = 1'b1;
    exp_pulses++;
    check("R7 digit", digit, exp_digit);
    check("R7 tone", tone_en, 1);
    check("R3 pulses", pulses, exp_pulses);
    pdata = ~c;
    tick(8);
    check("R8 hold digit", digit, exp_digit);
    ce_n = 1'b1;
    tick(6);
    exp_tone = 1'b0;
    check("R8 tone off", tone_en, 0);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    check("R1 digit", digit, 0);
    check("R1 tone", tone_en, 0);
    check("R1 valid", code_valid, 0);
    tick(4);
    ce_n = 1'b0;
    tick(4);

    // directed serial words
    ser_cmd_check(5'h05);
    ser_cmd_check(5'h00);
    ser_cmd_check(5'h0F);
    ser_cmd_check(5'h15);
    ser_cmd_check(5'h1E);
    ser_cmd_check(5'h1F);
    ser_cmd_check(5'h1F);
    ser_cmd_check(5'h0A);

    // R11: exact strobe cycle
    ser_cmd_check(5'h1F);
    for (int i = 0; i < 4; i++) ser_bit(1'b0 ^ (i == 1) ^ (i == 2));
    sdata = 1'b0;
    tick(HALF);
    sclk = 1'b0;
    tick(3);
    check("R11 valid early", code_valid, 0);
    check("R11 tone early", tone_en, 0);
    tick(1);
    check("R11 valid", code_valid, 1);
    check("R11 digit", digit, 6);
    tick(1);
    check("R11 pulse width R3", code_valid, 0);
    tick(HALF);
    sclk = 1'b1;
    tick(4);
    exp_digit = 4'h6;
    exp_tone = 1'b1;
    exp_pulses++;

    // R6: abort partial word with chip enable
    for (int i = 0; i < 3; i++) ser_bit(1'b1);
    ce_n = 1'b1;
    tick(6);
    exp_tone = 1'b0;
    check("R6 tone off", tone_en, 0);
    ce_n = 1'b0;
    tick(4);
    ser_cmd_check(5'h09);

    // R9: parallel pins ignored in serial mode
    pdata = 4'h3;
    tick(8);
    pdata = 4'hC;
    tick(8);
    check("R9 serial digit", digit, exp_digit);
    check("R9 serial tone", tone_en, 1);

    // R10: mode change clears tone and partial word
    for (int i = 0; i < 2; i++) ser_bit(1'b1);
    mode_par = 1'b1;
    tick(6);
    exp_tone = 1'b0;
    check("R10 tone off", tone_en, 0);
    mode_par = 1'b0;
    tick(6);
    ser_cmd_check(5'h0C);

    // parallel mode
    ce_n = 1'b1;
    tick(4);
    mode_par = 1'b1;
    tick(6);
    exp_tone = 1'b0;
    par_cmd_check(4'h7);
    par_cmd_check(4'h0);
    par_cmd_check(4'hF);

    // R9: serial clock ignored in parallel mode
    pdata = 4'h2;
    tick(4);
    ce_n = 1'b0;
    tick(8);
    exp_digit = 4'h2;
    exp_tone = 1'b1;
    exp_pulses++;
    ser_send(5'h03);
    ser_send(5'h1F);
    check("R9 par digit", digit, 2);
    check("R9 par tone", tone_en, 1);
    check("R9 par pulses", pulses, exp_pulses);
    ce_n = 1'b1;
    tick(6);
    exp_tone = 1'b0;

    // random parallel
    void'($urandom(32'd2718));
    for (int k = 0; k < 12; k++) par_cmd_check(4'($urandom()));

    // random serial
    mode_par = 1'b0;
    tick(6);
    ce_n = 1'b0;
    tick(6);
    for (int k = 0; k < 40; k++) ser_cmd_check(5'($urandom()));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule